// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Ring Manager

This block keeps two small rings of buffer descriptors for a simple Ethernet DMA path, one for receive and one for transmit. Each descriptor lives in an internal register array and has a 16-bit status field and a length. Transmit descriptors also hold a data pointer. Ownership of a descriptor is decided by one status bit, and the last descriptor of each ring carries a wrap flag that closes the ring. Data movement itself is not modelled: a received frame is presented as a length plus two flags, and a transmitted frame is represented by its pointer and length while the engine works on it.

On the receive side, incoming frames fill empty descriptors in ring order. A consumer sees the descriptor at its consume index, together with a qualification that tells it whether the frame may be delivered upward and its payload length, which excludes the 4 trailing CRC bytes. The consumer then hands the descriptor back. If a frame arrives while the descriptor at the fill index is still owned by the consumer, the frame is dropped and the receive engine stalls until the consumer returns a descriptor.

On the transmit side, a host queues frames, which become ready descriptors. An engine drains ready descriptors in ring order after a latency set by the length. A separate scrub pass reclaims finished descriptors and keeps the count of clean ones, which is what gates queuing.

Top module: `bd_ring_mgr`

State machines and transitions:
- Receive engine: `RX_RUN` goes to `RX_STALL` when a frame finds its fill descriptor occupied. `RX_STALL` goes back to `RX_RUN` on a valid return of a descriptor.
- Scrub pass: `SC_IDLE` goes to `SC_WALK` on a scrub request. `SC_WALK` stays while it can reclaim a descriptor, and goes back to `SC_IDLE` at the first ready descriptor or once every descriptor is clean.
- Transmit engine: `EN_IDLE` goes to `EN_SEND` when the descriptor at the drain index is ready. `EN_SEND` goes back to `EN_IDLE` when its latency count reaches zero, and completes the descriptor on that cycle.

## Requirements
- R1: After reset every receive descriptor has status bit 15 (EMPTY) set and a length of zero. Only the last one also has bit 13 (WRAP) set. The consumer view shows status 0x8000 at index 0, and rx_avail is 0.
- R2: After reset tx_clean equals the ring size, the transmit engine is idle, and no scrub is running.
- R3: A queue request with length 0, with length above 1500, or with tx_clean at 0 is refused. tx_q_refuse pulses one cycle later and tx_clean does not change.
- R4: An accepted queue request stores its length and pointer at the producer index and sets bits 11 (LAST), 10 (transmit CRC) and 15 (READY). The producer index advances modulo the ring size, tx_clean drops by 1, and tx_q_accept pulses one cycle later.
- R5: The transmit engine takes READY descriptors in ring order and shows their pointer and length. For a descriptor that becomes READY at edge k, tx_done pulses at edge k+2+(length/4), and READY is cleared at that edge.
- R6: A scrub request walks one descriptor per cycle from the reclaim index while tx_clean is below the ring size. It stops at the first descriptor that is still READY. Each reclaimed descriptor keeps only WRAP (on the last index) and adds 1 to tx_clean. tx_clean never exceeds the ring size.
- R7: A frame accepted into the empty descriptor at the fill index clears EMPTY, stores the length, and sets bit 11 (LAST) and bit 1 (ERR) from rx_in_last and rx_in_err, keeping WRAP on the last index. The fill index wraps modulo the ring size.
- R8: rx_out_deliver is 1 only for an occupied descriptor with LAST set, ERR clear and a stored length minus 4 above 14. rx_out_dlen is the stored length minus 4.
- R9: rx_take on an occupied descriptor sets it back to EMPTY (plus WRAP on the last index) with zero length, advances the consume index modulo the ring size, and returns a stalled receive engine to running.
- R10: A frame that arrives while the fill descriptor is occupied, or while the engine is stalled, is not stored. rx_drop pulses one cycle later and rx_stall goes to 1.
- R11: rx_take while no descriptor is occupied has no effect on the descriptors or the consume index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in_valid | input | 1 | A received frame is presented this cycle |
| rx_in_len | input | LEN_W | Received length including 4 CRC bytes |
| rx_in_last | input | 1 | Frame ends in this descriptor |
| rx_in_err | input | 1 | Frame received with an error |
| rx_drop | output | 1 | Pulse: the previous frame was dropped |
| rx_stall | output | 1 | Receive engine is stalled |
| rx_avail | output | 1 | Descriptor at the consume index is occupied |
| rx_out_status | output | 16 | Status of the descriptor at the consume index |
| rx_out_len | output | LEN_W | Stored length at the consume index |
| rx_out_deliver | output | 1 | The frame qualifies for delivery |
| rx_out_dlen | output | LEN_W | Delivered length (stored minus 4) |
| rx_take | input | 1 | Consumer returns the descriptor at the consume index |
| tx_q_valid | input | 1 | Host queues a frame |
| tx_q_len | input | LEN_W | Frame length |
| tx_q_ptr | input | PTR_W | Frame data pointer |
| tx_q_accept | output | 1 | Pulse: the previous request was queued |
| tx_q_refuse | output | 1 | Pulse: the previous request was refused |
| tx_scrub | input | 1 | Start a reclaim pass |
| tx_scrub_busy | output | 1 | Reclaim pass in progress |
| tx_clean | output | $clog2(RING+1) | Clean descriptor count |
| tx_send_active | output | 1 | Transmit engine is working on a descriptor |
| tx_send_ptr | output | PTR_W | Pointer of the descriptor being sent |
| tx_send_len | output | LEN_W | Length of the descriptor being sent |
| tx_done | output | 1 | Pulse: a descriptor was completed |

## Verification
The checker watches on every cycle that invalid queue lengths are refused on the next cycle, that an accepted request lowers the clean count by exactly one, and that the clean count never exceeds the ring size. It also watches that completions only follow an active send, that a delivered frame has LAST set, ERR clear and a payload above 14 bytes, and that a frame arriving while stalled is dropped. Only the bench scenarios can show ring order across a wrap, the exact stored flag patterns, the completion latency, a scrub that stops at a still-ready descriptor, and recovery after a consumer returns a descriptor.

// File: rtl/bd_pkg.sv
package bd_pkg;
    localparam int STAT_W = 16;
    localparam int B_OWN  = 15;   // EMPTY on receive, READY on transmit
    localparam int B_WRAP = 13;
    localparam int B_LAST = 11;
    localparam int B_TXC  = 10;
    localparam int B_ERR  = 1;
    localparam int CRC_BYTES = 4;
    localparam int MIN_PAYLOAD = 14;

    typedef enum logic { RX_RUN, RX_STALL } rx_state_e;
    typedef enum logic { SC_IDLE, SC_WALK } scrub_state_e;
    typedef enum logic { EN_IDLE, EN_SEND } eng_state_e;
endpackage

// File: rtl/bd_rx_ring.sv
module bd_rx_ring
    import bd_pkg::*;
#(
    parameter int RING  = 4,
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              in_last,
    input  logic              in_err,
    output logic              drop,
    output logic              stall,
    output logic              avail,
    output logic [STAT_W-1:0] out_status,
    output logic [LEN_W-1:0]  out_len,
    output logic              out_deliver,
    output logic [LEN_W-1:0]  out_dlen,
    input  logic              take
);
    localparam int IW = (RING > 1) ? $clog2(RING) : 1;
    localparam logic [STAT_W-1:0] WRAP_M = STAT_W'(1) << B_WRAP;
    localparam logic [STAT_W-1:0] OWN_M  = STAT_W'(1) << B_OWN;

    function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
        return (i == IW'(RING - 1)) ? '0 : i + 1'b1;
    endfunction

    function automatic logic [STAT_W-1:0] wrap_of(input logic [IW-1:0] i);
        return (i == IW'(RING - 1)) ? WRAP_M : '0;
    endfunction

    logic [STAT_W-1:0] st_q  [RING];
    logic [LEN_W-1:0]  len_q [RING];
    logic [IW-1:0]     fill_q, cons_q;
    rx_state_e         state_q, state_d;
    logic              wr, take_ok, drop_d, drop_q;

    assign wr      = in_valid && (state_q == RX_RUN) && st_q[fill_q][B_OWN];
    assign drop_d  = in_valid && !wr;
    assign take_ok = take && !st_q[cons_q][B_OWN];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_RUN:   if (drop_d && !take_ok) state_d = RX_STALL;
            RX_STALL: if (take_ok) state_d = RX_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RING; i++) begin
                st_q[i]  <= OWN_M | wrap_of(IW'(i));
                len_q[i] <= '0;
            end
            fill_q <= '0;
            cons_q <= '0;
            drop_q <= 1'b0;
        end else begin
            drop_q <= drop_d;
            if (wr) begin
                st_q[fill_q] <= wrap_of(fill_q)
                              | (in_last ? (STAT_W'(1) << B_LAST) : '0)
                              | (in_err  ? (STAT_W'(1) << B_ERR)  : '0);
                len_q[fill_q] <= in_len;
                fill_q <= nxt(fill_q);
            end
            if (take_ok) begin
                st_q[cons_q]  <= OWN_M | wrap_of(cons_q);
                len_q[cons_q] <= '0;
                cons_q <= nxt(cons_q);
            end
        end
    end

    assign drop        = drop_q;
    assign stall       = (state_q == RX_STALL);
    assign avail       = !st_q[cons_q][B_OWN];
    assign out_status  = st_q[cons_q];
    assign out_len     = len_q[cons_q];
    assign out_dlen    = len_q[cons_q] - LEN_W'(CRC_BYTES);
    assign out_deliver = avail && st_q[cons_q][B_LAST] && !st_q[cons_q][B_ERR]
                      && (len_q[cons_q] > LEN_W'(CRC_BYTES + MIN_PAYLOAD));
endmodule

// File: rtl/bd_tx_ring.sv
module bd_tx_ring
    import bd_pkg::*;
#(
    parameter int RING    = 4,
    parameter int LEN_W   = 12,
    parameter int PTR_W   = 32,
    parameter int MAX_LEN = 1500,
    localparam int IW = (RING > 1) ? $clog2(RING) : 1,
    localparam int CW = $clog2(RING + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             q_valid,
    input  logic [LEN_W-1:0] q_len,
    input  logic [PTR_W-1:0] q_ptr,
    output logic             q_accept,
    output logic             q_refuse,
    input  logic             scrub,
    output logic             scrub_busy,
    output logic [CW-1:0]    clean,
    input  logic [IW-1:0]    eng_idx,
    output logic             eng_ready,
    output logic [LEN_W-1:0] eng_len,
    output logic [PTR_W-1:0] eng_ptr,
    input  logic             eng_clr
);
    localparam logic [STAT_W-1:0] WRAP_M = STAT_W'(1) << B_WRAP;
    localparam logic [STAT_W-1:0] SET_M  = (STAT_W'(1) << B_OWN)
                                         | (STAT_W'(1) << B_LAST)
                                         | (STAT_W'(1) << B_TXC);

    function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
        return (i == IW'(RING - 1)) ? '0 : i + 1'b1;
    endfunction

    function automatic logic [STAT_W-1:0] wrap_of(input logic [IW-1:0] i);
        return (i == IW'(RING - 1)) ? WRAP_M : '0;
    endfunction

    logic [STAT_W-1:0] st_q  [RING];
    logic [LEN_W-1:0]  len_q [RING];
    logic [PTR_W-1:0]  ptr_q [RING];
    logic [IW-1:0]     prod_q, recl_q;
    logic [CW-1:0]     clean_q;
    scrub_state_e      sc_q, sc_d;
    logic              q_ok, walk_go, acc_q, ref_q;

    assign q_ok = q_valid && (q_len != '0) && (q_len <= LEN_W'(MAX_LEN)) && (clean_q != '0);
    assign walk_go = (sc_q == SC_WALK) && (clean_q < CW'(RING)) && !st_q[recl_q][B_OWN];

    always_comb begin
        sc_d = sc_q;
        unique case (sc_q)
            SC_IDLE: if (scrub) sc_d = SC_WALK;
            SC_WALK: if (!walk_go) sc_d = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sc_q <= SC_IDLE;
        else        sc_q <= sc_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RING; i++) begin
                st_q[i]  <= wrap_of(IW'(i));
                len_q[i] <= '0;
                ptr_q[i] <= '0;
            end
            prod_q  <= '0;
            recl_q  <= '0;
            clean_q <= CW'(RING);
            acc_q   <= 1'b0;
            ref_q   <= 1'b0;
        end else begin
            acc_q   <= q_ok;
            ref_q   <= q_valid && !q_ok;
            clean_q <= clean_q + CW'(walk_go) - CW'(q_ok);
            if (q_ok) begin
                st_q[prod_q]  <= st_q[prod_q] | SET_M;
                len_q[prod_q] <= q_len;
                ptr_q[prod_q] <= q_ptr;
                prod_q <= nxt(prod_q);
            end
            if (walk_go) begin
                st_q[recl_q] <= wrap_of(recl_q);
                recl_q <= nxt(recl_q);
            end
            if (eng_clr) st_q[eng_idx][B_OWN] <= 1'b0;
        end
    end

    assign q_accept   = acc_q;
    assign q_refuse   = ref_q;
    assign scrub_busy = (sc_q == SC_WALK);
    assign clean      = clean_q;
    assign eng_ready  = st_q[eng_idx][B_OWN];
    assign eng_len    = len_q[eng_idx];
    assign eng_ptr    = ptr_q[eng_idx];
endmodule

// File: rtl/bd_tx_engine.sv
module bd_tx_engine
    import bd_pkg::*;
#(
    parameter int RING  = 4,
    parameter int LEN_W = 12,
    parameter int PTR_W = 32,
    localparam int IW = (RING > 1) ? $clog2(RING) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IW-1:0]    idx,
    input  logic             ready,
    input  logic [LEN_W-1:0] len,
    input  logic [PTR_W-1:0] ptr,
    output logic             clr,
    output logic             active,
    output logic [PTR_W-1:0] send_ptr,
    output logic [LEN_W-1:0] send_len,
    output logic             done
);
    eng_state_e       st_q, st_d;
    logic [LEN_W-1:0] cnt_q;
    logic [IW-1:0]    idx_q;
    logic [PTR_W-1:0] ptr_q;
    logic [LEN_W-1:0] len_q;
    logic             done_q;

    assign clr = (st_q == EN_SEND) && (cnt_q == '0);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EN_IDLE: if (ready) st_d = EN_SEND;
            EN_SEND: if (clr)   st_d = EN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= EN_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            ptr_q  <= '0;
            len_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= clr;
            if (st_q == EN_IDLE && ready) begin
                cnt_q <= len >> 2;
                ptr_q <= ptr;
                len_q <= len;
            end else if (st_q == EN_SEND && !clr) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (clr) idx_q <= (idx_q == IW'(RING - 1)) ? '0 : idx_q + 1'b1;
        end
    end

    assign idx      = idx_q;
    assign active   = (st_q == EN_SEND);
    assign send_ptr = ptr_q;
    assign send_len = len_q;
    assign done     = done_q;
endmodule

// File: rtl/bd_ring_mgr.sv
module bd_ring_mgr
    import bd_pkg::*;
#(
    parameter int RING    = 4,
    parameter int LEN_W   = 12,
    parameter int PTR_W   = 32,
    parameter int MAX_LEN = 1500
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_in_valid,
    input  logic [LEN_W-1:0]           rx_in_len,
    input  logic                       rx_in_last,
    input  logic                       rx_in_err,
    output logic                       rx_drop,
    output logic                       rx_stall,
    output logic                       rx_avail,
    output logic [15:0]                rx_out_status,
    output logic [LEN_W-1:0]           rx_out_len,
    output logic                       rx_out_deliver,
    output logic [LEN_W-1:0]           rx_out_dlen,
    input  logic                       rx_take,
    input  logic                       tx_q_valid,
    input  logic [LEN_W-1:0]           tx_q_len,
    input  logic [PTR_W-1:0]           tx_q_ptr,
    output logic                       tx_q_accept,
    output logic                       tx_q_refuse,
    input  logic                       tx_scrub,
    output logic                       tx_scrub_busy,
    output logic [$clog2(RING+1)-1:0]  tx_clean,
    output logic                       tx_send_active,
    output logic [PTR_W-1:0]           tx_send_ptr,
    output logic [LEN_W-1:0]           tx_send_len,
    output logic                       tx_done
);
    localparam int IW = (RING > 1) ? $clog2(RING) : 1;

    logic [IW-1:0]    eng_idx;
    logic             eng_ready, eng_clr;
    logic [LEN_W-1:0] eng_len;
    logic [PTR_W-1:0] eng_ptr;

    bd_rx_ring #(.RING(RING), .LEN_W(LEN_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rx_in_valid), .in_len(rx_in_len),
        .in_last(rx_in_last), .in_err(rx_in_err),
        .drop(rx_drop), .stall(rx_stall), .avail(rx_avail),
        .out_status(rx_out_status), .out_len(rx_out_len),
        .out_deliver(rx_out_deliver), .out_dlen(rx_out_dlen),
        .take(rx_take)
    );

    bd_tx_ring #(.RING(RING), .LEN_W(LEN_W), .PTR_W(PTR_W), .MAX_LEN(MAX_LEN)) u_txr (
        .clk(clk), .rst_n(rst_n),
        .q_valid(tx_q_valid), .q_len(tx_q_len), .q_ptr(tx_q_ptr),
        .q_accept(tx_q_accept), .q_refuse(tx_q_refuse),
        .scrub(tx_scrub), .scrub_busy(tx_scrub_busy), .clean(tx_clean),
        .eng_idx(eng_idx), .eng_ready(eng_ready), .eng_len(eng_len),
        .eng_ptr(eng_ptr), .eng_clr(eng_clr)
    );

    bd_tx_engine #(.RING(RING), .LEN_W(LEN_W), .PTR_W(PTR_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .idx(eng_idx), .ready(eng_ready), .len(eng_len), .ptr(eng_ptr),
        .clr(eng_clr), .active(tx_send_active),
        .send_ptr(tx_send_ptr), .send_len(tx_send_len), .done(tx_done)
    );
endmodule

// File: rtl/bd_ring_mgr_chk.sv
module bd_ring_mgr_chk
    import bd_pkg::*;
#(
    parameter int RING    = 4,
    parameter int LEN_W   = 12,
    parameter int PTR_W   = 32,
    parameter int MAX_LEN = 1500
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      rx_in_valid,
    input logic [LEN_W-1:0]          rx_in_len,
    input logic                      rx_drop,
    input logic                      rx_stall,
    input logic [15:0]               rx_out_status,
    input logic                      rx_out_deliver,
    input logic [LEN_W-1:0]          rx_out_dlen,
    input logic                      tx_q_valid,
    input logic [LEN_W-1:0]          tx_q_len,
    input logic                      tx_q_accept,
    input logic                      tx_q_refuse,
    input logic                      tx_scrub_busy,
    input logic [$clog2(RING+1)-1:0] tx_clean,
    input logic                      tx_send_active,
    input logic                      tx_done
);
    assert_bad_len_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_q_valid && (tx_q_len == '0 || tx_q_len > LEN_W'(MAX_LEN)) |=> tx_q_refuse && !tx_q_accept);

    assert_accept_takes_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_q_accept && !$past(tx_scrub_busy) |-> tx_clean == $past(tx_clean) - 1'b1);

    assert_clean_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clean <= ($clog2(RING+1))'(RING));

    assert_done_after_send_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> $past(tx_send_active));

    assert_deliver_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_out_deliver |-> rx_out_status[B_LAST] && !rx_out_status[B_ERR]
                           && rx_out_dlen > LEN_W'(MIN_PAYLOAD));

    assert_stalled_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_in_valid && rx_stall |=> rx_drop);
endmodule

bind bd_ring_mgr bd_ring_mgr_chk #(.RING(RING), .LEN_W(LEN_W), .PTR_W(PTR_W), .MAX_LEN(MAX_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .rx_in_valid(rx_in_valid), .rx_in_len(rx_in_len),
    .rx_drop(rx_drop), .rx_stall(rx_stall),
    .rx_out_status(rx_out_status), .rx_out_deliver(rx_out_deliver),
    .rx_out_dlen(rx_out_dlen),
    .tx_q_valid(tx_q_valid), .tx_q_len(tx_q_len),
    .tx_q_accept(tx_q_accept), .tx_q_refuse(tx_q_refuse),
    .tx_scrub_busy(tx_scrub_busy), .tx_clean(tx_clean),
    .tx_send_active(tx_send_active), .tx_done(tx_done)
);

// File: tb/bd_ring_mgr_test.sv
`timescale 1ns/1ps
module bd_ring_mgr_test;
    localparam int RING = 4, LEN_W = 12, PTR_W = 32;

    logic clk = 0, rst_n = 0;
    logic rx_in_valid = 0, rx_in_last = 0, rx_in_err = 0, rx_take = 0;
    logic [LEN_W-1:0] rx_in_len = '0;
    logic tx_q_valid = 0, tx_scrub = 0;
    logic [LEN_W-1:0] tx_q_len = '0;
    logic [PTR_W-1:0] tx_q_ptr = '0;
    logic rx_drop, rx_stall, rx_avail, rx_out_deliver;
    logic [15:0] rx_out_status;
    logic [LEN_W-1:0] rx_out_len, rx_out_dlen, tx_send_len;
    logic tx_q_accept, tx_q_refuse, tx_scrub_busy, tx_send_active, tx_done;
    logic [2:0] tx_clean;
    logic [PTR_W-1:0] tx_send_ptr;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    bd_ring_mgr uut (.*);

    localparam int NV = 8;
    localparam int V_LEN  [NV] = '{64, 18, 19, 100, 100, 1518, 4, 22};
    localparam int V_LAST [NV] = '{1, 1, 1, 0, 1, 1, 1, 1};
    localparam int V_ERR  [NV] = '{0, 0, 0, 0, 1, 0, 0, 1};
    localparam int V_DEL  [NV] = '{1, 0, 1, 0, 0, 1, 0, 0};
    localparam int V_DLEN [NV] = '{60, 14, 15, 96, 96, 1514, 0, 18};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic rx_push(input int len, input bit last, input bit err);
        @(negedge clk);
        rx_in_valid = 1; rx_in_len = LEN_W'(len); rx_in_last = last; rx_in_err = err;
        @(negedge clk);
        rx_in_valid = 0;
    endtask

    task automatic rx_give_back();
        @(negedge clk); rx_take = 1;
        @(negedge clk); rx_take = 0;
    endtask

    task automatic tx_queue(input int len, input logic [31:0] ptr);
        @(negedge clk);
        tx_q_valid = 1; tx_q_len = LEN_W'(len); tx_q_ptr = ptr;
        @(negedge clk);
        tx_q_valid = 0;
    endtask

    task automatic tx_run_scrub();
        @(negedge clk); tx_scrub = 1;
        @(negedge clk); tx_scrub = 0;
        for (int k = 0; k < 20 && tx_scrub_busy; k++) @(negedge clk);
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!tx_done && n < 1000) begin @(negedge clk); n++; end
    endtask

    initial begin
        int n;
        logic [15:0] exp_st;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // Reset state
        chk("R1 reset status", rx_out_status, 32'h8000);
        chk("R1 reset avail", rx_avail, 0);
        chk("R1 reset len", rx_out_len, 0);
        chk("R2 reset clean", tx_clean, RING);
        chk("R2 reset engine", tx_send_active, 0);
        chk("R2 reset scrub", tx_scrub_busy, 0);

        // R11: return with nothing occupied
        rx_give_back();
        chk("R11 take empty avail", rx_avail, 0);
        chk("R11 take empty status", rx_out_status, 32'h8000);

        // Vector walk: fill, qualify, consume (R7, R8, R9)
        for (int i = 0; i < NV; i++) begin
            rx_push(V_LEN[i], V_LAST[i] != 0, V_ERR[i] != 0);
            exp_st = ((i % RING) == RING-1 ? 16'h2000 : 16'h0)
                   | (V_LAST[i] != 0 ? 16'h0800 : 16'h0)
                   | (V_ERR[i] != 0 ? 16'h0002 : 16'h0);
            chk($sformatf("R7 vec%0d avail", i), rx_avail, 1);
            chk($sformatf("R7 vec%0d status", i), rx_out_status, exp_st);
            chk($sformatf("R7 vec%0d len", i), rx_out_len, V_LEN[i]);
            chk($sformatf("R8 vec%0d deliver", i), rx_out_deliver, V_DEL[i]);
            if (V_DEL[i] != 0) chk($sformatf("R8 vec%0d dlen", i), rx_out_dlen, V_DLEN[i]);
            rx_give_back();
            exp_st = 16'h8000 | (((i % RING) == RING-2) ? 16'h2000 : 16'h0);
            chk($sformatf("R9 vec%0d next empty", i), rx_out_status, exp_st);
            chk($sformatf("R9 vec%0d avail", i), rx_avail, 0);
        end

        // Overflow and stall (R10, R9)
        for (int i = 0; i < RING; i++) begin
            rx_push(64, 1, 0);
            chk("R10 fill no drop", rx_drop, 0);
        end
        rx_push(70, 1, 0);
        chk("R10 full drop", rx_drop, 1);
        chk("R10 full stall", rx_stall, 1);
        rx_push(70, 1, 0);
        chk("R10 stalled drop", rx_drop, 1);
        rx_give_back();
        chk("R9 reenable", rx_stall, 0);
        rx_push(80, 1, 0);
        chk("R10 after reenable no drop", rx_drop, 0);
        chk("R9 next consume status", rx_out_status, 32'h0800);
        chk("R9 next consume len", rx_out_len, 64);
        for (int i = 0; i < RING; i++) rx_give_back();
        chk("R9 drained avail", rx_avail, 0);

        // Transmit: refusals
        tx_queue(0, 32'h10);
        chk("R3 len0 refuse", tx_q_refuse, 1);
        chk("R3 len0 no accept", tx_q_accept, 0);
        tx_queue(1501, 32'h10);
        chk("R3 len1501 refuse", tx_q_refuse, 1);
        chk("R3 clean unchanged", tx_clean, RING);

        // Accept, latency, scrub
        tx_queue(8, 32'h1000);
        chk("R4 accept", tx_q_accept, 1);
        chk("R4 clean dec", tx_clean, RING-1);
        @(negedge clk);
        chk("R5 active", tx_send_active, 1);
        chk("R4 stored ptr", tx_send_ptr, 32'h1000);
        chk("R4 stored len", tx_send_len, 8);
        wait_done(n);
        chk("R5 latency", n + 1, 4);
        tx_run_scrub();
        chk("R6 reclaim one", tx_clean, RING);

        // Fill the ring, refuse when clean is zero
        for (int i = 0; i < RING; i++) begin
            tx_queue(400, 32'h2000 + 32'(i) * 32'h100);
            chk("R4 ring accept", tx_q_accept, 1);
        end
        chk("R4 ring clean zero", tx_clean, 0);
        tx_queue(1500, 32'h9000);
        chk("R3 clean zero refuse", tx_q_refuse, 1);
        tx_run_scrub();
        chk("R6 scrub stops at ready", tx_clean, 0);
        chk("R5 first in order", tx_send_ptr, 32'h2000);
        wait_done(n);
        @(negedge clk); @(negedge clk);
        chk("R5 second in order", tx_send_ptr, 32'h2100);
        tx_run_scrub();
        chk("R6 reclaim up to ready", tx_clean, 1);
        for (int i = 0; i < RING-1; i++) begin
            wait_done(n);
            @(negedge clk);
        end
        tx_run_scrub();
        chk("R6 reclaim all", tx_clean, RING);
        chk("R6 scrub idle", tx_scrub_busy, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule